// File: doc/BRIEF.md
# Word-Wide Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit for a load/store processor datapath. It takes two operand words and a 3-bit operation code. It returns a result word, a flag that is high when the result is all zeros, and a signed-overflow flag.

Five operations are supported: bitwise AND, bitwise OR, addition, subtraction and set-less-than. A single ripple-carry chain of one-bit adder slices serves all the arithmetic. The top bit of the operation code inverts the second operand and also supplies the carry-in of 1, so subtraction is two's-complement addition. Every candidate result is formed at the same time, and the low two bits of the operation code choose which one reaches the output.

Set-less-than takes the raw sign bit of the internal difference and places it in bit 0 of the result. No overflow correction is applied to that bit. The block has no clock and no state.

Top module: `alu32_core`

## Requirements
- R1: Operation code 3'b000 drives the result with the bitwise AND of the two operands.
- R2: Operation code 3'b001 drives the result with the bitwise OR of the two operands.
- R3: Operation code 3'b010 drives the result with the sum of the operands modulo 2^32, with a carry-in of 0.
- R4: Operation code 3'b110 drives the result with A minus B modulo 2^32. It does this as A plus the inverted B plus a carry-in of 1.
- R5: Operation code 3'b111 places bit 31 of the raw difference A−B in result bit 0 and drives result bits 31..1 to 0. No overflow correction is applied, so a difference that overflows can give 0 even when A is below B as signed numbers.
- R6: The zero output is 1 exactly when all 32 result bits are 0, for every operation code.
- R7: Under operation codes 3'b010 and 3'b110, the overflow output is 1 exactly when the carry into bit 31 differs from the carry out of bit 31. This is the same as the signed result being out of range.
- R8: Under operation codes 3'b000, 3'b001 and 3'b111, the overflow output is 0.
- R9: Operation codes 3'b011, 3'b100 and 3'b101 drive a result of all zeros and an overflow of 0, so the zero output reads 1.
- R10: All outputs follow an input change within the same time step, with no register between input and output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand (inverted internally for subtract and set-less-than) |
| op_i | input | 3 | Operation code; bit 2 inverts B and sets the carry-in, bits 1..0 select the result |
| result_o | output | 32 | Selected result word |
| zero_o | output | 1 | High when result_o is all zeros |
| overflow_o | output | 1 | Signed overflow of add or subtract; 0 for all other codes |

## Verification
Every output is due zero cycles after its stimulus, because no storage lies on any path. The bench drives operands and the code away from the clock edge and waits one nanosecond for the ripple chain to settle. It samples result, zero flag and overflow flag together, before the next stimulus changes anything. The expected values come from plain integer arithmetic in the bench, including the raw-sign rule for set-less-than when the difference overflows.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned OPC_W  = 3;

    // bit 2 = invert B / carry-in, bits 1..0 = result select
    localparam logic [OPC_W-1:0] OPC_AND = 3'b000;
    localparam logic [OPC_W-1:0] OPC_OR  = 3'b001;
    localparam logic [OPC_W-1:0] OPC_ADD = 3'b010;
    localparam logic [OPC_W-1:0] OPC_SUB = 3'b110;
    localparam logic [OPC_W-1:0] OPC_SLT = 3'b111;

endpackage

// File: rtl/alu_adder_slice.sv
module alu_adder_slice (
    input  logic a_i,
    input  logic b_i,
    input  logic binv_i,
    input  logic cin_i,
    output logic sum_o,
    output logic cout_o
);
    logic b_eff_d;

    always_comb begin
        b_eff_d = b_i ^ binv_i;
        sum_o   = a_i ^ b_eff_d ^ cin_i;
        cout_o  = (a_i & b_eff_d) | (a_i & cin_i) | (b_eff_d & cin_i);
    end
endmodule

// File: rtl/alu_ripple_chain.sv
module alu_ripple_chain #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             binv_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             ovf_o
);
    logic [WIDTH:0] carry_d;

    assign carry_d[0] = binv_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu_adder_slice u_slice (
            .a_i    (a_i[i]),
            .b_i    (b_i[i]),
            .binv_i (binv_i),
            .cin_i  (carry_d[i]),
            .sum_o  (sum_o[i]),
            .cout_o (carry_d[i+1])
        );
    end

    assign ovf_o = carry_d[WIDTH-1] ^ carry_d[WIDTH];
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] data_i,
    output logic             zero_o
);
    assign zero_o = ~(|data_i);
endmodule

// File: rtl/alu32_core.sv
module alu32_core
    import alu32_pkg::*;
#(
    parameter int unsigned WIDTH = WORD_W
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [OPC_W-1:0] op_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             overflow_o
);
    localparam int unsigned MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] result;
        logic             ovf;
    } alu_out_t;

    alu_out_t         out_d;
    logic [WIDTH-1:0] sum_d;
    logic             chain_ovf_d;

    alu_ripple_chain #(.WIDTH(WIDTH)) u_chain (
        .a_i    (a_i),
        .b_i    (b_i),
        .binv_i (op_i[OPC_W-1]),
        .sum_o  (sum_d),
        .ovf_o  (chain_ovf_d)
    );

    always_comb begin
        out_d = '0;
        case (op_i)
            OPC_AND: out_d.result = a_i & b_i;
            OPC_OR:  out_d.result = a_i | b_i;
            OPC_ADD, OPC_SUB: begin
                out_d.result = sum_d;
                out_d.ovf    = chain_ovf_d;
            end
            OPC_SLT: out_d.result[0] = sum_d[MSB];
            default: out_d = '0;
        endcase
    end

    assign result_o   = out_d.result;
    assign overflow_o = out_d.ovf;

    alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
        .data_i (out_d.result),
        .zero_o (zero_o)
    );

    always_comb begin
        if (op_i == OPC_ADD) begin
            // R3
            add_sum_chk: assert (sum_d == WIDTH'(a_i + b_i));
        end
        if (op_i == OPC_SUB) begin
            // R4
            sub_diff_chk: assert (sum_d == WIDTH'(a_i - b_i));
        end
        if (op_i == OPC_SLT) begin
            // R5
            slt_upper_chk: assert (result_o[MSB:1] == '0);
        end
        if (op_i != OPC_ADD && op_i != OPC_SUB) begin
            // R8
            no_overflow_chk: assert (!overflow_o);
        end
        if (op_i == OPC_ADD || op_i == OPC_SUB) begin
            // R7
            ovf_sign_chk: assert (overflow_o ==
                ((a_i[MSB] == (b_i[MSB] ^ op_i[OPC_W-1])) && (sum_d[MSB] != a_i[MSB])));
        end
    end
endmodule

// File: tb/tb_alu32_core.sv
module tb_alu32_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a, b;
    logic [2:0]  op;
    logic [31:0] res;
    logic        zf, ovf;
    int          n_checks = 0;
    int          n_errors = 0;
    int          cyc = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    alu32_core dut (
        .a_i(a), .b_i(b), .op_i(op),
        .result_o(res), .zero_o(zf), .overflow_o(ovf)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [33:0] model(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
        logic [31:0] r;
        logic        v;
        logic [31:0] d;
        r = '0; v = 1'b0;
        d = x - y;
        case (o)
            3'b000: r = x & y;
            3'b001: r = x | y;
            3'b010: begin r = x + y; v = (x[31] == y[31]) && (r[31] != x[31]); end
            3'b110: begin r = d;     v = (x[31] != y[31]) && (r[31] != x[31]); end
            3'b111: r = {31'b0, d[31]};
            default: r = '0;
        endcase
        return {v, (r == 0), r};
    endfunction

    task automatic apply(input string tag, input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
        logic [33:0] e;
        @(negedge clk);
        op = o; a = x; b = y;
        #1;
        e = model(o, x, y);
        check({tag, " result"}, res, e[31:0]);
        check("R6 zero", {31'b0, zf}, {31'b0, e[32]});
        check({tag, " overflow"}, {31'b0, ovf}, {31'b0, e[33]});
    endtask

    task automatic t_logic();
        apply("R1 and", 3'b000, 32'hF0F0_1234, 32'h0FF0_FFFF);
        apply("R1 and", 3'b000, 32'hAAAA_AAAA, 32'h5555_5555);
        apply("R2 or",  3'b001, 32'hF000_0001, 32'h0000_1000);
        apply("R2 or",  3'b001, 32'h0, 32'h0);
    endtask

    task automatic t_add();
        apply("R3 add", 3'b010, 32'd100, 32'd23);
        apply("R3 add", 3'b010, 32'hFFFF_FFFF, 32'h1);
        apply("R7 add", 3'b010, 32'h7FFF_FFFF, 32'h1);
        apply("R7 add", 3'b010, 32'h8000_0000, 32'h8000_0000);
        apply("R7 add", 3'b010, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    endtask

    task automatic t_sub();
        apply("R4 sub", 3'b110, 32'd50, 32'd8);
        apply("R4 sub", 3'b110, 32'd5, 32'd9);
        apply("R4 sub", 3'b110, 32'h1234_5678, 32'h1234_5678);
        apply("R7 sub", 3'b110, 32'h8000_0000, 32'h1);
        apply("R7 sub", 3'b110, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    endtask

    task automatic t_slt();
        apply("R5 slt", 3'b111, 32'd3, 32'd7);
        apply("R5 slt", 3'b111, 32'd7, 32'd3);
        apply("R5 slt", 3'b111, 32'hFFFF_FFFE, 32'd1);
        apply("R5 slt", 3'b111, 32'd9, 32'd9);
        // raw sign: difference overflows, bit 0 reads 0 although A < B signed
        apply("R5 slt", 3'b111, 32'h8000_0000, 32'h1);
        apply("R8 slt", 3'b111, 32'h7FFF_FFFF, 32'h8000_0000);
    endtask

    task automatic t_unlisted();
        apply("R9 code3", 3'b011, 32'h8000_0000, 32'h1);
        apply("R9 code4", 3'b100, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        apply("R9 code5", 3'b101, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    endtask

    task automatic t_comb();
        // R10: output follows the new inputs in the same time step, no clock edge between
        @(negedge clk);
        op = 3'b010; a = 32'd1; b = 32'd2;
        #1 check("R10 comb", res, 32'd3);
        a = 32'd40;
        #1 check("R10 comb", res, 32'd42);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 5000 && !done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got %0d cycles expected under 5000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; op = 3'b000;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 idle result", res, 32'h0);
        check("R6 idle zero", {31'b0, zf}, 32'h1);
        check("R8 idle overflow", {31'b0, ovf}, 32'h0);
        t_logic();
        t_add();
        t_sub();
        t_slt();
        t_unlisted();
        t_comb();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule